// File: doc/BRIEF.md
# One-Wire Slave Address Command Layer

This block is the address-selection stage of a slave on a single-line, open-drain serial bus. It sits between a bit-level slot engine and a function-command layer. The slot engine turns bus waveforms into events: a bus reset, a received bit written by the master, and a request for the bit to drive in a master read slot. From those events this layer takes in an eight-bit address opcode, runs the matching address procedure against a 64-bit identity, and raises a one-cycle `selected` strobe when the function layer may take over.

The identity arrives on a port as 64 bits. Bits 7:0 hold the family byte, bits 55:8 hold the serial number, and bits 63:56 hold a check byte. The layer handles five commands: read-address, match, skip, search and resume. It keeps a resume flag across bus transactions, so a master that has already addressed this slave can reach it again without sending the identity a second time. A combinational self-check recomputes the check byte over the lower 56 identity bits and flags any mismatch.

Events are sampled on the rising clock edge. Every registered result appears in the cycle after the edge that consumed the event.

Top module: `owire_addr_layer`

## Requirements
- R1: After `rst_n` is released, `resume_flag`, `tx_en` and `selected` are 0, and the layer ignores bits until a bus reset. A `bus_reset` event in any state returns the layer to collecting an opcode, with opcode bits taken least significant first. A bus reset keeps the resume flag unchanged.
- R2: The read-address opcode is 33h when `alt_read` is 0 and 39h when `alt_read` is 1. The opcode that is not selected counts as unknown.
- R3: Read-address clears the resume flag once its opcode is complete. It then drives identity bits 0 to 63 in order on `tx_bit`, with `tx_en` high, one bit per read request. `selected` pulses after the 64th read request.
- R4: Match (55h) compares 64 master bits against identity bits 0 to 63. If all 64 agree, the resume flag is set and `selected` pulses, both in the cycle after the 64th bit.
- R5: On the first mismatching match bit, the resume flag is cleared. No `selected` follows, and all later bits are ignored until the next bus reset.
- R6: Skip (CCh) pulses `selected` in the cycle after the eighth opcode bit and leaves the resume flag unchanged.
- R7: For each identity bit, search (F0h) drives the true bit on the first read request and its complement on the second, with `tx_en` high. During the master-write phase that follows, `tx_en` is low.
- R8: In search, a master bit that differs from the identity bit clears the resume flag and silences the layer (`tx_en` low, no `selected`) until the next bus reset. A search that completes all 64 bits sets the resume flag and pulses `selected`.
- R9: Resume (A5h) pulses `selected` only when the resume flag is set. Otherwise the layer idles until the next bus reset.
- R10: After an unknown opcode, the layer stays idle until the next bus reset: `tx_en` stays low and `selected` stays low.
- R11: `crc_err` is combinational. It is 1 exactly when identity bits 63:56 differ from the check byte computed over bits 0 to 55. That check byte uses x^8+x^5+x^4+1, starts from zero, and shifts least significant bit first.
- R12: `selected` is a single-cycle pulse, and it follows only a received bit or a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | One-cycle event: a reset pulse was seen on the bus |
| rx_valid | input | 1 | One-cycle event: the master wrote a bit |
| rx_bit | input | 1 | Value of the bit the master wrote, valid with `rx_valid` |
| rd_req | input | 1 | One-cycle event: a master read slot consumes `tx_bit` |
| alt_read | input | 1 | Selects the alternate read-address opcode |
| id_code | input | 64 | Identity: family byte in bits 7:0, serial number in bits 55:8, check byte in bits 63:56 |
| tx_en | output | 1 | The layer drives the data of the next read slot |
| tx_bit | output | 1 | Bit for the next read slot (1 when `tx_en` is low) |
| selected | output | 1 | One-cycle strobe that hands control to the function layer |
| resume_flag | output | 1 | Resume flag state |
| crc_err | output | 1 | Self-check: the stored check byte mismatches the computed one |

## Verification
Every event is driven on a falling edge, held through one rising edge, and released at the next falling edge. Registered results (`selected`, `resume_flag`, `tx_en`, `tx_bit`) are due in exactly that one cycle, so the bench reads them at the release point. It reads `selected` there after the last opcode bit, the last match or search bit, or the last read request, and it also confirms the strobe has dropped one cycle later. `tx_bit` and `tx_en` are read before each read request is issued, because they must already be valid when the slot engine consumes them. `crc_err` is combinational, so it is checked one cycle after `id_code` changes.

// File: rtl/owa_pkg.sv
package owa_pkg;

    localparam logic [7:0] OPC_READ_STD = 8'h33;
    localparam logic [7:0] OPC_READ_ALT = 8'h39;
    localparam logic [7:0] OPC_MATCH    = 8'h55;
    localparam logic [7:0] OPC_SKIP     = 8'hCC;
    localparam logic [7:0] OPC_SEARCH   = 8'hF0;
    localparam logic [7:0] OPC_RESUME   = 8'hA5;

    localparam int unsigned CHK_W = 8;
    localparam logic [CHK_W-1:0] CHK_POLY_REFL = 8'h8C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_READ,
        ST_MATCH,
        ST_SRCH,
        ST_FUNC
    } state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_READ,
        CMD_MATCH,
        CMD_SKIP,
        CMD_SRCH,
        CMD_RESUME
    } cmd_t;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_WRITE
    } phase_t;

endpackage

// File: rtl/owa_opdecode.sv
module owa_opdecode
    import owa_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       alt_read,
    output cmd_t       cmd
);
    always_comb begin
        unique case (opcode)
            OPC_READ_STD: cmd = alt_read ? CMD_NONE : CMD_READ;
            OPC_READ_ALT: cmd = alt_read ? CMD_READ : CMD_NONE;
            OPC_MATCH:    cmd = CMD_MATCH;
            OPC_SKIP:     cmd = CMD_SKIP;
            OPC_SEARCH:   cmd = CMD_SRCH;
            OPC_RESUME:   cmd = CMD_RESUME;
            default:      cmd = CMD_NONE;
        endcase
    end
endmodule

// File: rtl/owa_crc8.sv
module owa_crc8
    import owa_pkg::*;
#(
    parameter int unsigned DATA_W = 56
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  crc
);
    always_comb begin
        logic [CHK_W-1:0] acc;
        logic             fb;
        acc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            fb  = acc[0] ^ data[i];
            acc = acc >> 1;
            if (fb) acc = acc ^ CHK_POLY_REFL;
        end
        crc = acc;
    end
endmodule

// File: rtl/owire_addr_layer.sv
module owire_addr_layer
    import owa_pkg::*;
#(
    parameter int unsigned ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_reset,
    input  logic            rx_valid,
    input  logic            rx_bit,
    input  logic            rd_req,
    input  logic            alt_read,
    input  logic [ID_W-1:0] id_code,
    output logic            tx_en,
    output logic            tx_bit,
    output logic            selected,
    output logic            resume_flag,
    output logic            crc_err
);
    localparam int unsigned IDX_W  = $clog2(ID_W);
    localparam int unsigned BODY_W = ID_W - CHK_W;
    localparam int unsigned OPC_W  = 8;
    localparam int unsigned OCNT_W = $clog2(OPC_W);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(ID_W - 1);
    localparam logic [OCNT_W-1:0] LAST_OPC = OCNT_W'(OPC_W - 1);

    typedef struct packed {
        state_t            state;
        phase_t            phase;
        logic [IDX_W-1:0]  idx;
        logic [OCNT_W-1:0] bcnt;
        logic [OPC_W-1:0]  opc;
        logic              resume;
        logic              sel;
    } regs_t;

    regs_t            d, q;
    logic [OPC_W-1:0] opc_next;
    cmd_t             cmd;
    logic             cur_bit;
    logic             last_bit;
    logic [CHK_W-1:0] crc_calc;

    assign opc_next = {rx_bit, q.opc[OPC_W-1:1]};
    assign cur_bit  = id_code[q.idx];
    assign last_bit = (q.idx == LAST_IDX);

    owa_opdecode u_dec (
        .opcode   (opc_next),
        .alt_read (alt_read),
        .cmd      (cmd)
    );

    owa_crc8 #(.DATA_W(BODY_W)) u_crc (
        .data (id_code[BODY_W-1:0]),
        .crc  (crc_calc)
    );

    always_comb begin
        d     = q;
        d.sel = 1'b0;
        if (bus_reset) begin
            d.state = ST_OPC;
            d.bcnt  = '0;
            d.idx   = '0;
            d.phase = PH_TRUE;
        end else begin
            unique case (q.state)
                ST_OPC: if (rx_valid) begin
                    d.opc  = opc_next;
                    d.bcnt = q.bcnt + 1'b1;
                    if (q.bcnt == LAST_OPC) begin
                        d.idx   = '0;
                        d.phase = PH_TRUE;
                        unique case (cmd)
                            CMD_READ: begin
                                d.state  = ST_READ;
                                d.resume = 1'b0;
                            end
                            CMD_MATCH: d.state = ST_MATCH;
                            CMD_SRCH:  d.state = ST_SRCH;
                            CMD_SKIP: begin
                                d.state = ST_FUNC;
                                d.sel   = 1'b1;
                            end
                            CMD_RESUME: begin
                                d.state = q.resume ? ST_FUNC : ST_IDLE;
                                d.sel   = q.resume;
                            end
                            default: d.state = ST_IDLE;
                        endcase
                    end
                end
                ST_READ: if (rd_req) begin
                    if (last_bit) begin
                        d.state = ST_FUNC;
                        d.sel   = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_MATCH: if (rx_valid) begin
                    if (rx_bit != cur_bit) begin
                        d.state  = ST_IDLE;
                        d.resume = 1'b0;
                    end else if (last_bit) begin
                        d.state  = ST_FUNC;
                        d.resume = 1'b1;
                        d.sel    = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
                ST_SRCH: begin
                    unique case (q.phase)
                        PH_TRUE: if (rd_req) d.phase = PH_COMP;
                        PH_COMP: if (rd_req) d.phase = PH_WRITE;
                        default: if (rx_valid) begin
                            if (rx_bit != cur_bit) begin
                                d.state  = ST_IDLE;
                                d.resume = 1'b0;
                            end else if (last_bit) begin
                                d.state  = ST_FUNC;
                                d.resume = 1'b1;
                                d.sel    = 1'b1;
                            end else begin
                                d.idx   = q.idx + 1'b1;
                                d.phase = PH_TRUE;
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: PH_TRUE, idx: '0, bcnt: '0,
                   opc: '0, resume: 1'b0, sel: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tx_en       = (q.state == ST_READ) ||
                         ((q.state == ST_SRCH) && (q.phase != PH_WRITE));
    assign tx_bit      = !tx_en ? 1'b1 :
                         ((q.state == ST_SRCH) && (q.phase == PH_COMP)) ? ~cur_bit : cur_bit;
    assign selected    = q.sel;
    assign resume_flag = q.resume;
    assign crc_err     = (crc_calc != id_code[ID_W-1:BODY_W]);

endmodule

// File: rtl/owa_checker.sv
module owa_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic rx_valid,
    input logic rd_req,
    input logic tx_en,
    input logic selected,
    input logic resume_flag
);
    AST_SEL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        selected |=> !selected); // R12

    AST_SEL_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> $past(rx_valid || rd_req)); // R12

    AST_RESUME_RISE_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_flag) |-> selected); // R4

    AST_RESUME_FALL_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(resume_flag) |-> $past(rx_valid)); // R5

    AST_QUIET_AFTER_BUS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!tx_en && !selected)); // R1

    AST_RESUME_KEPT_BY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> $stable(resume_flag)); // R1
endmodule

bind owire_addr_layer owa_checker u_chk (.*);

// File: tb/owire_addr_layer_bench.sv
module owire_addr_layer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rd_req = 1'b0;
    logic        alt_read = 1'b0;
    logic [63:0] id_code;
    logic        tx_en, tx_bit, selected, resume_flag, crc_err;

    int errors = 0;
    int checks = 0;

    localparam logic [47:0] SERIAL = 48'h5A3C_0F96_E17B;
    logic [63:0] good_id;

    always #4 clk = ~clk;

    owire_addr_layer u_owire_addr_layer (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .rd_req(rd_req), .alt_read(alt_read), .id_code(id_code),
        .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected),
        .resume_flag(resume_flag), .crc_err(crc_err)
    );

    function automatic logic [7:0] ref_crc(input logic [55:0] data);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic x = c[0] ^ data[i];
            c = {x, c[7:1]};
            c[3] = c[3] ^ x;
            c[2] = c[2] ^ x;
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); rx_valid = 1'b1; rx_bit = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic read_bit(output logic b, output logic en);
        @(negedge clk); b = tx_bit; en = tx_en; rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic sel_then_drop(input string tag, input logic exp);
        check({tag, " selected"}, selected, exp);
        @(negedge clk);
        check({tag, " strobe drop"}, selected, 1'b0);
    endtask

    task automatic do_match(input int flip_at);
        pulse_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit((i == flip_at) ? ~good_id[i] : good_id[i]);
    endtask

    task automatic t_reset_state();
        check("R1 reset tx_en", tx_en, 1'b0);
        check("R1 reset resume", resume_flag, 1'b0);
        check("R1 reset selected", selected, 1'b0);
        send_byte(8'hCC);
        check("R1 ignored before bus reset", selected, 1'b0);
    endtask

    task automatic t_crc();
        check("R11 good id", crc_err, 1'b0);
        @(negedge clk); id_code = good_id ^ 64'h0100_0000_0000_0000;
        @(negedge clk);
        check("R11 corrupt check byte", crc_err, 1'b1);
        @(negedge clk); id_code = good_id ^ 64'h0000_0000_0001_0000;
        @(negedge clk);
        check("R11 corrupt serial", crc_err, 1'b1);
        @(negedge clk); id_code = good_id;
        @(negedge clk);
    endtask

    task automatic t_read(input logic [7:0] opc, input string tag);
        logic b, en;
        int bad = 0;
        pulse_reset();
        send_byte(opc);
        check({tag, " R3 resume cleared"}, resume_flag, 1'b0);
        for (int i = 0; i < 64; i++) begin
            read_bit(b, en);
            if (b !== good_id[i] || en !== 1'b1) bad++;
        end
        check({tag, " R3 identity bits lsb first"}, bad, 0);
        sel_then_drop({tag, " R3 R12"}, 1'b1);
    endtask

    task automatic t_match_ok();
        do_match(-1);
        check("R4 resume set", resume_flag, 1'b1);
        sel_then_drop("R4 R12 match", 1'b1);
    endtask

    task automatic t_match_bad();
        t_match_ok();
        do_match(10);
        check("R5 no select", selected, 1'b0);
        check("R5 resume cleared", resume_flag, 1'b0);
        check("R5 silent", tx_en, 1'b0);
    endtask

    task automatic t_alt_read();
        logic b, en;
        alt_read = 1'b1;
        pulse_reset();
        send_byte(8'h33);
        read_bit(b, en);
        check("R2 R10 std opcode unknown when alt", en, 1'b0);
        check("R10 unknown no select", selected, 1'b0);
        t_read(8'h39, "R2 alt");
        alt_read = 1'b0;
        pulse_reset();
        send_byte(8'h39);
        read_bit(b, en);
        check("R2 alt opcode unknown when std", en, 1'b0);
    endtask

    task automatic t_skip();
        t_match_ok();
        pulse_reset();
        send_byte(8'hCC);
        check("R6 resume kept", resume_flag, 1'b1);
        sel_then_drop("R6 skip", 1'b1);
    endtask

    task automatic t_resume();
        t_match_ok();
        pulse_reset();
        send_byte(8'hA5);
        sel_then_drop("R9 resume set", 1'b1);
        t_read(8'h33, "R9 clear");
        pulse_reset();
        send_byte(8'hA5);
        sel_then_drop("R9 resume clear", 1'b0);
    endtask

    task automatic t_search(input int flip_at);
        logic b, en;
        int bad = 0;
        pulse_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            if (flip_at >= 0 && i > flip_at) break;
            read_bit(b, en);
            if (b !== good_id[i] || en !== 1'b1) bad++;
            read_bit(b, en);
            if (b !== ~good_id[i] || en !== 1'b1) bad++;
            if (tx_en !== 1'b0) bad++;
            send_bit((i == flip_at) ? ~good_id[i] : good_id[i]);
        end
        check("R7 search true/complement/write", bad, 0);
        if (flip_at < 0) begin
            check("R8 search resume set", resume_flag, 1'b1);
            sel_then_drop("R8 search", 1'b1);
        end else begin
            check("R8 drop-out no select", selected, 1'b0);
            check("R8 drop-out resume", resume_flag, 1'b0);
            read_bit(b, en);
            check("R8 drop-out silent", en, 1'b0);
        end
    endtask

    task automatic t_reset_midway();
        logic b, en;
        pulse_reset();
        send_byte(8'h33);
        for (int i = 0; i < 10; i++) read_bit(b, en);
        pulse_reset();
        check("R1 bus reset stops read", tx_en, 1'b0);
        send_byte(8'hCC);
        sel_then_drop("R1 opcode after bus reset", 1'b1);
    endtask

    task automatic t_unknown();
        logic b, en;
        pulse_reset();
        send_byte(8'h00);
        check("R10 unknown no select", selected, 1'b0);
        send_byte(8'hCC);
        read_bit(b, en);
        check("R10 idle until reset", selected, 1'b0);
        check("R10 no drive", en, 1'b0);
    endtask

    initial begin
        good_id = {ref_crc({SERIAL, 8'h31}), SERIAL, 8'h31};
        id_code = good_id;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_crc();
        t_read(8'h33, "R3 std");
        t_match_ok();
        t_read(8'h33, "R3 after match");
        t_alt_read();
        t_match_bad();
        t_skip();
        t_resume();
        t_search(-1);
        t_search(5);
        t_reset_midway();
        t_unknown();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule